// File: doc/BRIEF.md
# Result Bus Arbiter with Trap Abort

This block decides which functional unit of a scoreboard-style core may write back its result in the current cycle. Every unit with a finished result raises a request. The arbiter grants exactly one of them per cycle, lowest index first. It then places that unit's register value, destination tag and status-change vector on the shared result bus. A unit never sends a full copy of the status register. It sends a one-hot vector of changes, where each bit names one kind of trap.

A non-zero change vector from the granted unit commits a trap, and it does so only because that unit won the bus. A change vector from a unit that lost arbitration has no effect. One cycle after the commit, the block pulses a global abort. The abort resets every functional unit to idle and cancels their pending requests. In the same cycle the block raises privilege to machine level, records the old privilege, and redirects fetch to the trap-vector address that was sampled in the commit cycle. Instruction issue stays blocked from the commit cycle until every unit reports idle.

Units that can never change status have their change inputs tied to zero by a build parameter, so nothing is routed from them.

Top module: `cdb_arbiter`

## Requirements
- R1: In each cycle at most one grant bit is set, and only for a unit that is requesting. While a grant is given, `bus_valid_o` is high and the bus carries that unit's value and tag in the same cycle.
- R2: Among simultaneous requesters, the unit with the lowest index wins.
- R3: The status-change vector is one-hot, with one bit per trap kind. The bus shows the granted unit's vector. A unit that requests with a non-zero vector but is not granted changes neither privilege nor abort.
- R4: `abort_o` is high for exactly one cycle: the cycle after a grant whose vector is non-zero. The trapping unit's own write-back completes in its grant cycle.
- R5: No grant is given in a cycle where `abort_o` is high, even when units are requesting.
- R6: `issue_en_o` is low from the trap commit cycle onward. It returns high one cycle after the first cycle in which `abort_o` is low and all `idle_i` bits are 1.
- R7: A unit whose bit in `STATUS_UNITS` is 0 always has its change vector treated as zero. Its grant never commits a trap.
- R8: On a trap commit, `priv_o` becomes 3 (machine) and `prev_priv_o` takes the value `priv_o` had before. Both new values are visible in the abort cycle.
- R9: `redirect_o` pulses together with `abort_o`, and `redirect_pc_o` equals `tvec_i` as it was sampled in the commit cycle.
- R10: After reset no grant is given, `abort_o` and `redirect_o` are 0, `issue_en_o` is 1, and both privilege outputs are 0 (user).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_UNITS | Result-ready request for each unit |
| idle_i | input | N_UNITS | Unit is in its idle state |
| res_data_i | input | N_UNITS*DATA_W | Result value of each unit, packed |
| res_tag_i | input | N_UNITS*TAG_W | Destination register tag of each unit, packed |
| res_delta_i | input | N_UNITS*DELTA_W | One-hot status-change vector of each unit, packed |
| tvec_i | input | ADDR_W | Trap-vector address |
| gnt_o | output | N_UNITS | One-hot grant |
| bus_valid_o | output | 1 | Result bus carries a write-back |
| bus_data_o | output | DATA_W | Result value on the bus |
| bus_tag_o | output | TAG_W | Destination tag on the bus |
| bus_delta_o | output | DELTA_W | Committed status-change vector |
| abort_o | output | 1 | Global flush pulse |
| issue_en_o | output | 1 | Instruction issue permitted |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | ADDR_W | Fetch redirect target |
| priv_o | output | 2 | Current privilege level |
| prev_priv_o | output | 2 | Privilege before the last trap |

## Verification
The assertions check, on every cycle, these invariants:
- grant exclusivity and lowest-index priority;
- the absence of grants in an abort cycle;
- the one-cycle shape of the abort pulse and its link to a trapping grant in the cycle before;
- the tie-off of change vectors from units that cannot trap;
- the privilege update.

Some behaviour depends on input sequences, and only the bench scenarios show it:
- issue staying blocked until the idle bits arrive;
- a loser's change vector being ignored;
- the redirect target being the address sampled at commit;
- privilege being saved across two traps in a row.

The bench sweeps every request pattern over four units and computes the expected winner arithmetically.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int PRIV_W = 2;
  localparam logic [PRIV_W-1:0] PRIV_USER    = 2'd0;
  localparam logic [PRIV_W-1:0] PRIV_MACHINE = 2'd3;
endpackage

// File: rtl/cdb_prio_arb.sv
module cdb_prio_arb #(
  parameter int N_UNITS = 4,
  localparam int IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [N_UNITS-1:0] req_i,
  input  logic               block_i,
  output logic [N_UNITS-1:0] gnt_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N_UNITS - 1; i >= 0; i--) begin
      if (req_i[i] && !block_i) begin
        gnt_o = '0;
        gnt_o[i] = 1'b1;
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cdb_result_mux.sv
module cdb_result_mux #(
  parameter int N_UNITS = 4,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 5,
  parameter int DELTA_W = 4,
  parameter logic [N_UNITS-1:0] STATUS_UNITS = {N_UNITS{1'b1}},
  localparam int IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic [N_UNITS*DATA_W-1:0]  data_i,
  input  logic [N_UNITS*TAG_W-1:0]   tag_i,
  input  logic [N_UNITS*DELTA_W-1:0] delta_i,
  input  logic [IDX_W-1:0]           idx_i,
  input  logic                       valid_i,
  output logic [DATA_W-1:0]          data_o,
  output logic [TAG_W-1:0]           tag_o,
  output logic [DELTA_W-1:0]         delta_o
);
  logic [DELTA_W-1:0] delta_eff [N_UNITS];

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    if (STATUS_UNITS[u]) begin : g_live
      assign delta_eff[u] = delta_i[u*DELTA_W +: DELTA_W];
    end else begin : g_tied
      assign delta_eff[u] = '0;
    end
  end

  always_comb begin
    data_o  = '0;
    tag_o   = '0;
    delta_o = '0;
    for (int u = 0; u < N_UNITS; u++) begin
      if (valid_i && idx_i == IDX_W'(u)) begin
        data_o  = data_i[u*DATA_W +: DATA_W];
        tag_o   = tag_i[u*TAG_W +: TAG_W];
        delta_o = delta_eff[u];
      end
    end
  end
endmodule

// File: rtl/cdb_trap_ctrl.sv
module cdb_trap_ctrl
  import cdb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic              idle_all_i,
  input  logic [ADDR_W-1:0] tvec_i,
  output logic              abort_o,
  output logic              issue_en_o,
  output logic [ADDR_W-1:0] redirect_pc_o,
  output logic [PRIV_W-1:0] priv_o,
  output logic [PRIV_W-1:0] prev_priv_o
);
  logic abort_q, hold_q;
  logic [ADDR_W-1:0] pc_q;
  logic [PRIV_W-1:0] priv_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_q <= 1'b0;
      hold_q  <= 1'b0;
      pc_q    <= '0;
      priv_q  <= PRIV_USER;
      prev_q  <= PRIV_USER;
    end else begin
      abort_q <= commit_i;
      if (commit_i) begin
        hold_q <= 1'b1;
        pc_q   <= tvec_i;
        prev_q <= priv_q;
        priv_q <= PRIV_MACHINE;
      end else if (!abort_q && idle_all_i) begin
        hold_q <= 1'b0;
      end
    end
  end

  // block issue already in the commit cycle so no younger op slips in
  assign issue_en_o    = !hold_q && !commit_i;
  assign abort_o       = abort_q;
  assign redirect_pc_o = pc_q;
  assign priv_o        = priv_q;
  assign prev_priv_o   = prev_q;
endmodule

// File: rtl/cdb_arbiter.sv
module cdb_arbiter
  import cdb_pkg::*;
#(
  parameter int N_UNITS = 4,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 5,
  parameter int DELTA_W = 4,
  parameter int ADDR_W  = 32,
  parameter logic [N_UNITS-1:0] STATUS_UNITS = {N_UNITS{1'b1}}
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_UNITS-1:0]         req_i,
  input  logic [N_UNITS-1:0]         idle_i,
  input  logic [N_UNITS*DATA_W-1:0]  res_data_i,
  input  logic [N_UNITS*TAG_W-1:0]   res_tag_i,
  input  logic [N_UNITS*DELTA_W-1:0] res_delta_i,
  input  logic [ADDR_W-1:0]          tvec_i,
  output logic [N_UNITS-1:0]         gnt_o,
  output logic                       bus_valid_o,
  output logic [DATA_W-1:0]          bus_data_o,
  output logic [TAG_W-1:0]           bus_tag_o,
  output logic [DELTA_W-1:0]         bus_delta_o,
  output logic                       abort_o,
  output logic                       issue_en_o,
  output logic                       redirect_o,
  output logic [ADDR_W-1:0]          redirect_pc_o,
  output logic [PRIV_W-1:0]          priv_o,
  output logic [PRIV_W-1:0]          prev_priv_o
);
  localparam int IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1;

  logic [IDX_W-1:0] win_idx;
  logic             win_any;
  logic             commit;

  cdb_prio_arb #(.N_UNITS(N_UNITS)) u_arb (
    .req_i  (req_i),
    .block_i(abort_o),
    .gnt_o  (gnt_o),
    .idx_o  (win_idx),
    .any_o  (win_any)
  );

  cdb_result_mux #(
    .N_UNITS(N_UNITS), .DATA_W(DATA_W), .TAG_W(TAG_W),
    .DELTA_W(DELTA_W), .STATUS_UNITS(STATUS_UNITS)
  ) u_mux (
    .data_i (res_data_i),
    .tag_i  (res_tag_i),
    .delta_i(res_delta_i),
    .idx_i  (win_idx),
    .valid_i(win_any),
    .data_o (bus_data_o),
    .tag_o  (bus_tag_o),
    .delta_o(bus_delta_o)
  );

  // one-hot deltas: OR of the committed bits is the trap
  assign commit      = win_any && (|bus_delta_o);
  assign bus_valid_o = win_any;

  cdb_trap_ctrl #(.ADDR_W(ADDR_W)) u_trap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit),
    .idle_all_i   (&idle_i),
    .tvec_i       (tvec_i),
    .abort_o      (abort_o),
    .issue_en_o   (issue_en_o),
    .redirect_pc_o(redirect_pc_o),
    .priv_o       (priv_o),
    .prev_priv_o  (prev_priv_o)
  );

  assign redirect_o = abort_o;
endmodule

// File: rtl/cdb_arbiter_chk.sv
module cdb_arbiter_chk #(
  parameter int N_UNITS = 4,
  parameter int DELTA_W = 4,
  parameter logic [N_UNITS-1:0] STATUS_UNITS = {N_UNITS{1'b1}}
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_UNITS-1:0] req_i,
  input logic [N_UNITS-1:0] idle_i,
  input logic [N_UNITS-1:0] gnt_o,
  input logic               bus_valid_o,
  input logic [DELTA_W-1:0] bus_delta_o,
  input logic               abort_o,
  input logic               issue_en_o,
  input logic               redirect_o,
  input logic [1:0]         priv_o,
  input logic [1:0]         prev_priv_o
);
  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0) && (bus_valid_o == (gnt_o != '0))); // R1
  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> ((req_i & (gnt_o - 1'b1)) == '0)); // R2
  AST_DELTA_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bus_delta_o)); // R3
  AST_ABORT_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(abort_o) |-> $past(bus_valid_o && (bus_delta_o != '0))); // R4
  AST_ABORT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o); // R4
  AST_NO_GNT_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (gnt_o == '0)); // R5
  AST_ISSUE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !issue_en_o); // R6
  AST_ISSUE_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(issue_en_o) && $past(rst_ni)) |-> $past(&idle_i)); // R6
  AST_TIED_DELTA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~STATUS_UNITS) != '0) |-> (bus_delta_o == '0)); // R7
  AST_PRIV_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (priv_o == 2'd3 && prev_priv_o == $past(priv_o))); // R8
  AST_REDIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o == abort_o); // R9
endmodule

bind cdb_arbiter cdb_arbiter_chk #(
  .N_UNITS(N_UNITS), .DELTA_W(DELTA_W), .STATUS_UNITS(STATUS_UNITS)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .idle_i(idle_i),
  .gnt_o(gnt_o), .bus_valid_o(bus_valid_o), .bus_delta_o(bus_delta_o),
  .abort_o(abort_o), .issue_en_o(issue_en_o), .redirect_o(redirect_o),
  .priv_o(priv_o), .prev_priv_o(prev_priv_o)
);

// File: tb/cdb_arbiter_bench.sv
module cdb_arbiter_bench;
  localparam int N = 4, DW = 16, TW = 3, XW = 4, AW = 16;
  localparam logic [N-1:0] LIVE = 4'b1011;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req = '0, idle = '1, gnt;
  logic [N*DW-1:0] data;
  logic [N*TW-1:0] tag;
  logic [N*XW-1:0] delta = '0;
  logic [AW-1:0] tvec = '0, rpc;
  logic bus_valid, abort, issue_en, redirect;
  logic [DW-1:0] bus_data;
  logic [TW-1:0] bus_tag;
  logic [XW-1:0] bus_delta;
  logic [1:0] priv, prev;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cdb_arbiter #(.N_UNITS(N), .DATA_W(DW), .TAG_W(TW), .DELTA_W(XW),
                .ADDR_W(AW), .STATUS_UNITS(LIVE)) u_cdb_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .idle_i(idle),
    .res_data_i(data), .res_tag_i(tag), .res_delta_i(delta), .tvec_i(tvec),
    .gnt_o(gnt), .bus_valid_o(bus_valid), .bus_data_o(bus_data),
    .bus_tag_o(bus_tag), .bus_delta_o(bus_delta), .abort_o(abort),
    .issue_en_o(issue_en), .redirect_o(redirect), .redirect_pc_o(rpc),
    .priv_o(priv), .prev_priv_o(prev));

  initial begin
    for (int u = 0; u < N; u++) begin
      data[u*DW +: DW] = DW'(16'h1000 + u * 16'h0111);
      tag[u*TW +: TW]  = TW'(u + 1);
    end
  end

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic set_delta(input int u, input logic [XW-1:0] d);
    delta[u*XW +: XW] = d;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #2;
    chk("R10", "gnt", gnt, 0);
    chk("R10", "abort", abort, 0);
    chk("R10", "redirect", redirect, 0);
    chk("R10", "issue_en", issue_en, 1);
    chk("R10", "priv", priv, 0);
    chk("R10", "prev", prev, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 R2: sweep all request patterns, no traps
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      req = 4'(p);
      #1;
      begin
        logic [3:0] e;
        int w;
        e = 4'(p) & (~4'(p) + 4'd1);
        w = 0;
        for (int k = 3; k >= 0; k--) if (e[k]) w = k;
        chk("R2", "gnt", gnt, e);
        chk("R1", "bus_valid", bus_valid, p != 0);
        if (p != 0) begin
          chk("R1", "bus_data", bus_data, 16'h1000 + w * 16'h0111);
          chk("R1", "bus_tag", bus_tag, w + 1);
        end
        chk("R1", "issue_en", issue_en, 1);
      end
    end

    // R3: losing unit's delta ignored
    @(negedge clk);
    req = 4'b1010; set_delta(3, 4'b0100);
    #1;
    chk("R3", "gnt loser", gnt, 4'b0010);
    chk("R3", "bus_delta loser", bus_delta, 0);
    @(negedge clk);
    req = '0; set_delta(3, '0);
    chk("R3", "no abort", abort, 0);
    chk("R3", "priv kept", priv, 0);

    // R7: tied-off unit 2 delta ignored
    @(negedge clk);
    req = 4'b0100; set_delta(2, 4'b0001);
    #1;
    chk("R7", "gnt", gnt, 4'b0100);
    chk("R7", "bus_delta", bus_delta, 0);
    chk("R7", "issue_en", issue_en, 1);
    @(negedge clk);
    req = '0; set_delta(2, '0);
    chk("R7", "no abort", abort, 0);
    chk("R7", "priv kept", priv, 0);

    // trap from unit 0 while unit 1 waits
    @(negedge clk);
    req = 4'b0011; set_delta(0, 4'b0010); tvec = 16'hBEE0; idle = 4'b0000;
    #1;
    chk("R4", "trap gnt", gnt, 4'b0001);
    chk("R4", "trap write-back data", bus_data, 16'h1000);
    chk("R3", "bus_delta", bus_delta, 4'b0010);
    chk("R6", "issue blocked at commit", issue_en, 0);
    @(negedge clk);
    tvec = 16'h0000; set_delta(0, '0); req = 4'b0010;
    #1;
    chk("R4", "abort pulse", abort, 1);
    chk("R5", "no gnt in abort", gnt, 0);
    chk("R9", "redirect", redirect, 1);
    chk("R9", "redirect_pc", rpc, 16'hBEE0);
    chk("R8", "priv", priv, 3);
    chk("R8", "prev", prev, 0);
    chk("R6", "issue blocked abort", issue_en, 0);
    @(negedge clk);
    req = '0;
    chk("R4", "abort single", abort, 0);
    chk("R9", "redirect single", redirect, 0);
    chk("R6", "issue held no idle", issue_en, 0);
    @(negedge clk);
    chk("R6", "issue still held", issue_en, 0);
    idle = 4'b0111;
    @(negedge clk);
    chk("R6", "partial idle", issue_en, 0);
    idle = 4'b1111;
    #1;
    chk("R6", "same-cycle idle", issue_en, 0);
    @(negedge clk);
    chk("R6", "issue resumes", issue_en, 1);

    // second trap from unit 3 saves machine level
    @(negedge clk);
    req = 4'b1000; set_delta(3, 4'b1000); tvec = 16'h0040;
    @(negedge clk);
    req = '0; set_delta(3, '0);
    chk("R4", "abort 2", abort, 1);
    chk("R8", "priv 2", priv, 3);
    chk("R8", "prev 2", prev, 3);
    chk("R9", "redirect_pc 2", rpc, 16'h0040);
    @(negedge clk);
    chk("R4", "abort 2 single", abort, 0);
    @(negedge clk);
    chk("R6", "resume with idle", issue_en, 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule